// File: doc/BRIEF.md
# Supervisory Reset Controller with Watchdog

This block generates the reset for a processor subsystem. It takes three reset sources. The first is an undervoltage flag from an external comparator. The second is an active-low push-button input. The third is a watchdog that the processor must service by toggling a strobe line. Every reset event is stretched, so the processor is held in reset for a fixed hold time after the last source goes away. The block drives an active-low reset and an active-high reset, and the two are always complementary.

The three external inputs are asynchronous to the block clock. Each passes through a synchronizer before it is used. The push-button input is also filtered, so that short low glitches do not reset the system. The watchdog counts clock cycles while the system runs. Any edge of the strobe restarts the count, in either direction. While reset is asserted the watchdog is held at zero, and it starts counting again from zero once reset releases. A watchdog-enable input models an unconnected strobe pin: when it is low, the watchdog can never cause a reset. All durations are parameters in clock cycles.

The controller is a three-state machine:

- `ST_HOLD` means a level source (undervoltage or push-button) is active.
- `ST_STRETCH` means the hold timer is running.
- `ST_RUN` means reset is released.

The transitions are:

- HOLD→STRETCH when the level sources clear. The hold timer restarts.
- STRETCH→HOLD when a level source returns.
- STRETCH→RUN when the hold timer reaches its last count.
- RUN→HOLD when a level source appears.
- RUN→STRETCH on a watchdog expiry. The hold timer restarts.

The block's own reset puts the machine in STRETCH with the timer at zero.

Top module: `sup_reset_ctrl`

## Requirements

In these requirements, H is `RST_HOLD_CYC`, W is `WDT_CYC` and F is `MR_FILT_CYC`. Edge counts start at 1 with the first rising edge that samples the new input value. All timings assume the default two-flop synchronizers.

- R1: Reset asserts while `rst_n` is low. After `rst_n` deasserts, `sys_rst_n` goes high on the H-th rising edge.
- R2: When `uv_flag` goes high, `sys_rst_n` goes low on the 3rd rising edge. It stays low for as long as the flag stays high.
- R3: When the last active level source clears, `sys_rst_n` goes high on rising edge H+3. A level source is `uv_flag` high or a qualified `mr_n` low.
- R4: A low pulse on `mr_n` that is sampled on fewer than F consecutive rising edges has no effect on `sys_rst_n`.
- R5: An `mr_n` low that lasts at least F sampled edges drives `sys_rst_n` low on rising edge F+2.
- R6: With `wd_en` high and the strobe held constant, `sys_rst_n` goes low W cycles after it went high. It then stays low for exactly H cycles.
- R7: Every rising edge and every falling edge of `wd_strobe` restarts the watchdog. Toggling the strobe at intervals shorter than W never causes a reset.
- R8: While `wd_en` is low, the watchdog never asserts reset, however long the strobe stays constant.
- R9: The watchdog is held at zero while reset is asserted. After any release, a full W cycles without a strobe edge is needed before it expires.
- R10: If a level source asserts while the hold timer is running, the timer reloads. The full H+3 edges are then counted again from the moment that source clears.
- R11: `sys_rst` is always the complement of `sys_rst_n`.

## Ports

| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Block power-on reset, active low, asynchronous |
| uv_flag | input | 1 | Undervoltage indication from external comparator, active high |
| mr_n | input | 1 | Push-button reset request, active low, asynchronous |
| wd_strobe | input | 1 | Watchdog service strobe; either edge services it |
| wd_en | input | 1 | Watchdog enable; low models an unconnected strobe pin |
| sys_rst_n | output | 1 | System reset, active low |
| sys_rst | output | 1 | System reset, active high |

## Verification

The bench builds the block with a hold time of 20 cycles, a watchdog period of 40 cycles and a filter of 4 cycles. With these values, a watchdog expiry, a full stretch and a repeated expiry loop all fit within a few hundred cycles. The short filter also makes it cheap to probe both sides of the glitch threshold, at F-1 and F samples. The directed cases measure exact edge counts for each source. After that, seeded random toggling of all four inputs is compared cycle by cycle against a reference model in the bench. This random phase reaches the interactions between sources: a retrigger during the stretch, a strobe edge right at expiry, and the enable changing mid-count.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef enum logic [1:0] {
        ST_HOLD    = 2'd0,
        ST_STRETCH = 2'd1,
        ST_RUN     = 2'd2
    } sup_state_t;

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
    parameter int   STAGES = 2,
    parameter logic INIT   = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= INIT;
                else        chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= {STAGES{INIT}};
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sup_mr_filter.sv
module sup_mr_filter #(
    parameter int FILT_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mr_s,
    output logic mr_act
);
    localparam int          CW  = (FILT_CYC > 1) ? $clog2(FILT_CYC) : 1;
    localparam logic [CW-1:0] LIM = CW'(FILT_CYC - 1);

    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             low_cnt <= '0;
        else if (mr_s)          low_cnt <= '0;
        else if (low_cnt != LIM) low_cnt <= low_cnt + 1'b1;
    end

    assign mr_act = !mr_s && (low_cnt == LIM);

    AST_MR_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mr_act) |-> $past(!mr_s)); // R4
endmodule

// File: rtl/sup_watchdog.sv
module sup_watchdog #(
    parameter int WDT_CYC = 1600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_s,
    input  logic wd_en,
    input  logic run,
    output logic expire
);
    localparam int          WW   = $clog2(WDT_CYC + 1);
    localparam logic [WW-1:0] LAST = WW'(WDT_CYC - 1);

    logic          strobe_d;
    logic          strobe_edge;
    logic [WW-1:0] wcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) strobe_d <= 1'b0;
        else        strobe_d <= strobe_s;
    end

    assign strobe_edge = strobe_s ^ strobe_d;
    assign expire      = wd_en && run && !strobe_edge && (wcnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                     wcnt <= '0;
        else if (!run || !wd_en || strobe_edge || expire) wcnt <= '0;
        else                                            wcnt <= wcnt + 1'b1;
    end

    AST_WD_FROZEN_IN_RST: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (wcnt == '0)); // R9
    AST_WD_EDGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_edge |=> !expire); // R7
endmodule

// File: rtl/sup_reset_ctrl.sv
module sup_reset_ctrl
    import sup_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int MR_FILT_CYC  = 8,
    parameter int RST_HOLD_CYC = 200,
    parameter int WDT_CYC      = 1600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic uv_flag,
    input  logic mr_n,
    input  logic wd_strobe,
    input  logic wd_en,
    output logic sys_rst_n,
    output logic sys_rst
);
    localparam int          HW    = $clog2(RST_HOLD_CYC + 1);
    localparam logic [HW-1:0] HLAST = HW'(RST_HOLD_CYC - 1);

    logic       uv_s, mr_s, strobe_s;
    logic       mr_act, wd_expire, lvl_req, in_run;
    sup_state_t state, nxt;
    logic [HW-1:0] hold_cnt, nxt_cnt;

    sup_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_sync_uv (
        .clk(clk), .rst_n(rst_n), .d(uv_flag), .q(uv_s));
    sup_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync_mr (
        .clk(clk), .rst_n(rst_n), .d(mr_n), .q(mr_s));
    sup_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_sync_wd (
        .clk(clk), .rst_n(rst_n), .d(wd_strobe), .q(strobe_s));

    sup_mr_filter #(.FILT_CYC(MR_FILT_CYC)) u_filt (
        .clk(clk), .rst_n(rst_n), .mr_s(mr_s), .mr_act(mr_act));

    sup_watchdog #(.WDT_CYC(WDT_CYC)) u_wdog (
        .clk(clk), .rst_n(rst_n), .strobe_s(strobe_s), .wd_en(wd_en),
        .run(in_run), .expire(wd_expire));

    assign lvl_req = uv_s | mr_act;
    assign in_run  = (state == ST_RUN);

    always_comb begin
        nxt     = state;
        nxt_cnt = hold_cnt;
        unique case (state)
            ST_HOLD: begin
                if (!lvl_req) begin
                    nxt     = ST_STRETCH;
                    nxt_cnt = '0;
                end
            end
            ST_STRETCH: begin
                if (lvl_req)                nxt = ST_HOLD;
                else if (hold_cnt == HLAST) nxt = ST_RUN;
                else                        nxt_cnt = hold_cnt + 1'b1;
            end
            ST_RUN: begin
                if (lvl_req) begin
                    nxt = ST_HOLD;
                end else if (wd_expire) begin
                    nxt     = ST_STRETCH;
                    nxt_cnt = '0;
                end
            end
            default: begin
                nxt     = ST_STRETCH;
                nxt_cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_STRETCH;
            hold_cnt <= '0;
        end else begin
            state    <= nxt;
            hold_cnt <= nxt_cnt;
        end
    end

    always_comb begin
        sys_rst_n = (state == ST_RUN);
        sys_rst   = (state != ST_RUN);
    end

    AST_UV_FORCES_RST: assert property (@(posedge clk) disable iff (!rst_n)
        uv_s |=> !sys_rst_n); // R2
    AST_HOLD_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        hold_cnt <= HLAST); // R3
    AST_EXPIRE_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_expire && !lvl_req) |=> (sys_rst && hold_cnt == '0)); // R6
    AST_RETRIGGER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STRETCH && lvl_req) |=> (state == ST_HOLD)); // R10
endmodule

// File: tb/sim_sup_reset_ctrl.sv
module sim_sup_reset_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int H = 20;
    localparam int W = 40;
    localparam int F = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic uv_flag = 1'b0;
    logic mr_n = 1'b1;
    logic wd_strobe = 1'b0;
    logic wd_en = 1'b0;
    logic sys_rst_n, sys_rst;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sup_reset_ctrl #(.SYNC_STAGES(2), .MR_FILT_CYC(F), .RST_HOLD_CYC(H), .WDT_CYC(W)) u0 (
        .clk(clk), .rst_n(rst_n), .uv_flag(uv_flag), .mr_n(mr_n),
        .wd_strobe(wd_strobe), .wd_en(wd_en), .sys_rst_n(sys_rst_n), .sys_rst(sys_rst));

    // Reference model built from the requirement latencies
    logic m_uv1, m_uv2, m_mr1, m_mr2, m_st1, m_st2, m_st3;
    int   m_run, m_ph, m_hc, m_wc;

    always @(posedge clk) begin
        bit lvl, edg, expd;
        int nph, nhc;
        if (!rst_n) begin
            m_uv1 = 0; m_uv2 = 0; m_mr1 = 1; m_mr2 = 1;
            m_st1 = 0; m_st2 = 0; m_st3 = 0;
            m_run = 0; m_ph = 1; m_hc = 0; m_wc = 0;
        end else begin
            lvl  = m_uv2 || (!m_mr2 && m_run >= F-1);
            edg  = m_st2 ^ m_st3;
            expd = wd_en && m_ph == 2 && !edg && m_wc == W-1;
            nph = m_ph; nhc = m_hc;
            if (lvl) begin nph = 0; nhc = 0; end
            else if (m_ph == 0) begin nph = 1; nhc = 0; end
            else if (m_ph == 1) begin
                if (m_hc == H-1) nph = 2; else nhc = m_hc + 1;
            end else if (expd) begin nph = 1; nhc = 0; end
            m_wc  = (m_ph != 2 || !wd_en || edg || expd) ? 0 : m_wc + 1;
            m_run = m_mr2 ? 0 : ((m_run >= F-1) ? m_run : m_run + 1);
            m_ph = nph; m_hc = nhc;
            m_st3 = m_st2; m_st2 = m_st1; m_st1 = wd_strobe;
            m_uv2 = m_uv1; m_uv1 = uv_flag;
            m_mr2 = m_mr1; m_mr1 = mr_n;
        end
    end

    // Per-cycle comparison against the model and output pairing
    always @(negedge clk) begin
        if (rst_n) begin
            n_chk++;
            if (sys_rst_n !== (m_ph == 2)) begin
                n_fail++;
                $display("FAIL model R2 R3 R5 R6 R7 R8 R10 at %0t: sys_rst_n=%0b expected %0b",
                         $time, sys_rst_n, (m_ph == 2));
            end
            n_chk++;
            if (sys_rst !== ~sys_rst_n) begin
                n_fail++;
                $display("FAIL R11: sys_rst=%0b expected %0b", sys_rst, ~sys_rst_n);
            end
        end
    end

    task automatic check(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic edges_to(input logic lvl, output int n);
        n = 0;
        do begin
            @(posedge clk); n++; @(negedge clk);
        end while (sys_rst_n !== lvl && n < 5000);
    endtask

    // Drive one source active for len sampled edges; report first low and first high edge
    task automatic pulse(input bit use_uv, input int len, input int limit,
                         output int t_low, output int t_high);
        t_low = 0; t_high = 0;
        if (use_uv) uv_flag = 1'b1; else mr_n = 1'b0;
        for (int i = 1; i <= limit; i++) begin
            @(posedge clk); @(negedge clk);
            if (i == len) begin uv_flag = 1'b0; mr_n = 1'b1; end
            if (t_low == 0 && sys_rst_n === 1'b0) t_low = i;
            if (t_low != 0 && t_high == 0 && sys_rst_n === 1'b1) t_high = i;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: run hung (actual incomplete, expected finished)");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int n, tl, th;
        bit stayed;
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        check("R1 reset state", sys_rst_n, 0);
        check("R11 reset state", sys_rst, 1);
        rst_n = 1'b1;
        edges_to(1'b1, n);
        check("R1 power-on hold", n, H);

        // R2 and R3: undervoltage
        pulse(1'b1, 30, 80, tl, th);
        check("R2 uv assert latency", tl, 3);
        check("R3 uv release", th, 30 + H + 3);

        // R4: glitch shorter than filter
        pulse(1'b0, F-1, 40, tl, th);
        check("R4 glitch ignored", tl, 0);

        // R5: exactly filter length, and R3 release via push-button
        pulse(1'b0, F, 60, tl, th);
        check("R5 mr assert latency", tl, F + 2);
        check("R3 mr release", th, F + H + 3);

        // R10: retrigger during stretch
        uv_flag = 1'b1;
        repeat (10) @(negedge clk);
        uv_flag = 1'b0;
        repeat (H/2) @(negedge clk);
        check("R10 mid-stretch still low", sys_rst_n, 0);
        pulse(1'b1, 2, 60, tl, th);
        check("R10 retrigger release", th, 2 + H + 3);

        // R9 and R6: long reset with no strobe, then watchdog expiry from release
        wd_en = 1'b1;
        uv_flag = 1'b1;
        repeat (2*W) @(negedge clk);
        uv_flag = 1'b0;
        edges_to(1'b1, n);
        check("R9 release after frozen watchdog", n, H + 3);
        edges_to(1'b0, n);
        check("R9 full period after release", n, W);
        edges_to(1'b1, n);
        check("R6 expiry pulse length", n, H);
        edges_to(1'b0, n);
        check("R6 repeated expiry period", n, W);
        edges_to(1'b1, n);

        // R7: servicing with alternating edges keeps reset released
        stayed = 1;
        for (int k = 0; k < 8; k++) begin
            for (int c = 0; c < W-6; c++) begin
                @(negedge clk);
                if (sys_rst_n !== 1'b1) stayed = 0;
            end
            wd_strobe = ~wd_strobe;
        end
        check("R7 serviced never resets", stayed, 1);

        // R8: disabled watchdog never expires
        wd_en = 1'b0;
        stayed = 1;
        for (int c = 0; c < 4*W; c++) begin
            @(negedge clk);
            if (sys_rst_n !== 1'b1) stayed = 0;
        end
        check("R8 disabled watchdog", stayed, 1);

        // Seeded random mix, checked against the model each cycle
        wd_en = 1'b1;
        for (int c = 0; c < 6000; c++) begin
            int r;
            @(negedge clk);
            r = $urandom % 1000;
            if (!uv_flag && r < 8)       uv_flag = 1'b1;
            else if (uv_flag && r < 120) uv_flag = 1'b0;
            r = $urandom % 1000;
            if (mr_n && r < 25)          mr_n = 1'b0;
            else if (!mr_n && r < 300)   mr_n = 1'b1;
            if (($urandom % 100) < 3)    wd_strobe = ~wd_strobe;
            if (($urandom % 1000) < 4)   wd_en = ~wd_en;
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule